// File: doc/BRIEF.md
# CAN-FD Transmitter Delay Compensation Unit

This block measures how long a transmitted edge takes to come back on the receive line of a CAN-FD node. It then derives the secondary sample point that the data phase uses to check its own transmitted bits. A strobe marks the moment the transmit line goes dominant at the start of the reserved bit that follows the FD-format bit. From then on a counter advances once per clock until the receive line shows the dominant level.

The captured delay plus a programmable offset gives the sample point position. The measurement can end too early if a dominant glitch appears inside the received FD-format bit. To guard against this, an optional filter window sets a lowest allowed sample point position. A dominant receive level that would give a smaller position is ignored.

The measurement runs once per frame, and only when bit-rate switching is active. If the data phase begins before a valid stop is seen, the result is marked not valid. The result is held until the next accepted start. Line levels use 0 for dominant and 1 for recessive.

Top module: `tdc_unit`

## Requirements
- R1: An accepted start strobe clears delayOut, sspPos and sspValid to 0 at the same clock edge that begins the measurement, and the delay counter restarts from 0.
- R2: A start strobe is accepted only when brsActive is 1, txLine is 0 (dominant) and no measurement is running. Otherwise it has no effect on the outputs or on a running measurement.
- R3: While measuring, the counter advances by one per clock. On the stop, delayOut takes the number of measuring cycles that passed before the cycle in which the stop condition was seen (0 if it was seen in the first measuring cycle), and sspValid becomes 1.
- R4: On completion, sspPos equals delayOut plus offsetVal, saturated to 2^SSP_W-1 (255 by default).
- R5: With filterEn at 0, the first measuring cycle in which rxLine is 0 stops the measurement.
- R6: With filterEn at 1, a cycle with rxLine at 0 stops the measurement only if the counter value plus offsetVal (saturated) is at least filterMin. Earlier dominant cycles are ignored and counting continues.
- R7: The delay counter saturates at 2^CNT_W-1 (127 by default) and does not wrap.
- R8: If dataPhaseStart is 1 in a measuring cycle without a stop, the measurement ends with sspValid at 0, and delayOut and sspPos take the counter value and its offset sum. A stop seen in the same cycle takes priority and gives a valid result.
- R9: delayOut, sspPos and sspValid hold their values from the end of a measurement until the next accepted start.
- R10: A synchronous reset (rst at 1) clears the counter, delayOut, sspPos and sspValid and aborts any measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst | input | 1 | Synchronous reset, active high |
| txLine | input | 1 | Transmit line level (0 dominant) |
| rxLine | input | 1 | Receive line level (0 dominant) |
| measStart | input | 1 | Strobe at the FD-format to reserved-bit transition |
| brsActive | input | 1 | Bit-rate switching is active for this frame |
| dataPhaseStart | input | 1 | Data phase begins; measurement deadline |
| offsetVal | input | OFS_W (8) | Delay compensation offset |
| filterMin | input | SSP_W (8) | Lowest accepted sample point position |
| filterEn | input | 1 | Enables the filter window |
| delayOut | output | CNT_W (7) | Captured loop delay |
| sspPos | output | SSP_W (8) | Secondary sample point position |
| sspValid | output | 1 | Result came from a valid stop |

## Verification
The hardest case to reach from the ports is a short dominant pulse inside the measuring window that must be ignored under the filter but must stop the count without it. A second hard case is a real edge that comes before the filter minimum is reached, so the stop is delayed to a later cycle while the receive line stays low. The stimulus places dominant pulses and the true edge at chosen measuring-cycle indices counted from the start strobe. It combines these with offsets and filter minimums that put the offset sum just below, at and above the minimum. Random frames then vary all of these together with the deadline.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

  typedef struct packed {
    logic clear;
    logic count;
    logic capture;
    logic fail;
  } tdcStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_MEAS = 1'b1
  } tdcState_t;

endpackage

// File: rtl/tdc_control.sv
module tdc_control
  import tdc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        measStart,
  input  logic        brsActive,
  input  logic        txLine,
  input  logic        dataPhaseStart,
  input  logic        stopOk,
  output tdcStrobes_t strobes
);

  tdcState_t state;
  tdcState_t nextState;
  logic      startOk;

  assign startOk = measStart && brsActive && !txLine;

  always_comb begin
    strobes   = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (startOk) begin
          strobes.clear = 1'b1;
          nextState     = ST_MEAS;
        end
      end
      ST_MEAS: begin
        if (stopOk) begin
          strobes.capture = 1'b1;
          nextState       = ST_IDLE;
        end else if (dataPhaseStart) begin
          strobes.fail = 1'b1;
          nextState    = ST_IDLE;
        end else begin
          strobes.count = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.clear, strobes.count, strobes.capture, strobes.fail}));

  // R2
  ignored_start_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !(measStart && brsActive && !txLine)) |=> state == ST_IDLE);

  // R2
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MEAS && !stopOk && !dataPhaseStart) |=> state == ST_MEAS);

  // R8
  deadline_end_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MEAS && dataPhaseStart) |=> state == ST_IDLE);

endmodule

// File: rtl/tdc_datapath.sv
module tdc_datapath
  import tdc_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int SSP_W = 8,
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  tdcStrobes_t      strobes,
  input  logic             rxLine,
  input  logic             filterEn,
  input  logic [OFS_W-1:0] offsetVal,
  input  logic [SSP_W-1:0] filterMin,
  output logic             stopOk,
  output logic [CNT_W-1:0] delayOut,
  output logic [SSP_W-1:0] sspPos,
  output logic             sspValid
);

  localparam int BASE_W = (CNT_W > OFS_W) ? CNT_W : OFS_W;
  localparam int SUM_W  = BASE_W + 1;
  localparam int SW     = (SUM_W > SSP_W) ? SUM_W : SSP_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;
  logic [SW-1:0]    sumFull;
  logic [SSP_W-1:0] sumSat;
  logic             windowOk;

  assign cntNext = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
  assign sumFull = SW'(cnt) + SW'(offsetVal);

  generate
    if (SUM_W > SSP_W) begin : g_sat
      localparam logic [SW-1:0] SSP_MAX_W = SW'({SSP_W{1'b1}});
      assign sumSat = (sumFull > SSP_MAX_W) ? {SSP_W{1'b1}} : sumFull[SSP_W-1:0];
    end else begin : g_nosat
      assign sumSat = sumFull[SSP_W-1:0];
    end
  endgenerate

  assign windowOk = !filterEn || (sumSat >= filterMin);
  assign stopOk   = !rxLine && windowOk;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      delayOut <= '0;
      sspPos   <= '0;
      sspValid <= 1'b0;
    end else begin
      if (strobes.clear) begin
        cnt      <= '0;
        delayOut <= '0;
        sspPos   <= '0;
        sspValid <= 1'b0;
      end
      if (strobes.count) cnt <= cntNext;
      if (strobes.capture) begin
        delayOut <= cnt;
        sspPos   <= sumSat;
        sspValid <= 1'b1;
      end
      if (strobes.fail) begin
        delayOut <= cnt;
        sspPos   <= sumSat;
        sspValid <= 1'b0;
      end
    end
  end

  // R7
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.count && cnt == CNT_MAX) |=> cnt == CNT_MAX);

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.count && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);

  // R6
  window_min_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.capture && filterEn) |=> sspPos >= $past(filterMin));

  // R3
  capture_rx_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sspValid) |-> $past(!rxLine));

  // R1
  clear_out_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.clear |=> (!sspValid && delayOut == '0 && sspPos == '0));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobes.clear && !strobes.capture && !strobes.fail)
      |=> ($stable(delayOut) && $stable(sspPos) && $stable(sspValid)));

endmodule

// File: rtl/tdc_unit.sv
module tdc_unit
  import tdc_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int SSP_W = 8,
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             txLine,
  input  logic             rxLine,
  input  logic             measStart,
  input  logic             brsActive,
  input  logic             dataPhaseStart,
  input  logic [OFS_W-1:0] offsetVal,
  input  logic [SSP_W-1:0] filterMin,
  input  logic             filterEn,
  output logic [CNT_W-1:0] delayOut,
  output logic [SSP_W-1:0] sspPos,
  output logic             sspValid
);

  tdcStrobes_t strobes;
  logic        stopOk;

  tdc_control u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .measStart      (measStart),
    .brsActive      (brsActive),
    .txLine         (txLine),
    .dataPhaseStart (dataPhaseStart),
    .stopOk         (stopOk),
    .strobes        (strobes)
  );

  tdc_datapath #(
    .CNT_W (CNT_W),
    .SSP_W (SSP_W),
    .OFS_W (OFS_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .rxLine    (rxLine),
    .filterEn  (filterEn),
    .offsetVal (offsetVal),
    .filterMin (filterMin),
    .stopOk    (stopOk),
    .delayOut  (delayOut),
    .sspPos    (sspPos),
    .sspValid  (sspValid)
  );

endmodule

// File: tb/tb_tdc_unit.sv
`timescale 1ns/1ps
module tb_tdc_unit;

  localparam int CMAX = 127;
  localparam int SMAX = 255;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       txLine = 1'b1;
  logic       rxLine = 1'b1;
  logic       measStart = 1'b0;
  logic       brsActive = 1'b0;
  logic       dataPhaseStart = 1'b0;
  logic [7:0] offsetVal = '0;
  logic [7:0] filterMin = '0;
  logic       filterEn = 1'b0;
  logic [6:0] delayOut;
  logic [7:0] sspPos;
  logic       sspValid;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;
  int lastDelay = 0, lastSsp = 0, lastValid = 0;

  always #5 clk = ~clk;

  tdc_unit dut (
    .clk(clk), .rst(rst), .txLine(txLine), .rxLine(rxLine),
    .measStart(measStart), .brsActive(brsActive),
    .dataPhaseStart(dataPhaseStart), .offsetVal(offsetVal),
    .filterMin(filterMin), .filterEn(filterEn),
    .delayOut(delayOut), .sspPos(sspPos), .sspValid(sspValid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit rxLowAt(int i, int gS, int gL, int edgeAt);
    return ((i >= gS) && (i < gS + gL)) || (i >= edgeAt);
  endfunction

  function automatic int sumOf(int c, int off);
    int s = c + off;
    return (s > SMAX) ? SMAX : s;
  endfunction

  task automatic expectFrame(input int off, input int fmin, input bit fen,
                             input int gS, input int gL, input int edgeAt,
                             input int deadline,
                             output int eDelay, output int eSsp, output int eValid);
    eDelay = 0; eSsp = 0; eValid = 0;
    for (int i = 0; i <= deadline; i++) begin
      int c = (i > CMAX) ? CMAX : i;
      int s = sumOf(c, off);
      if (rxLowAt(i, gS, gL, edgeAt) && (!fen || s >= fmin)) begin
        eDelay = c; eSsp = s; eValid = 1;
        return;
      end
      if (i == deadline) begin
        eDelay = c; eSsp = s; eValid = 0;
        return;
      end
    end
  endtask

  task automatic runFrame(input string tag, input int off, input int fmin,
                          input bit fen, input int gS, input int gL,
                          input int edgeAt, input int deadline, input int restartAt);
    int eD, eS, eV;
    expectFrame(off, fmin, fen, gS, gL, edgeAt, deadline, eD, eS, eV);
    @(negedge clk);
    offsetVal = 8'(off); filterMin = 8'(fmin); filterEn = fen;
    brsActive = 1'b1; txLine = 1'b0; rxLine = 1'b1; measStart = 1'b1;
    for (int i = 0; i <= deadline; i++) begin
      @(negedge clk);
      if (i == 0) begin
        // R1: outputs cleared by the accepted start
        chk({tag, " R1 clear valid"}, int'(sspValid), 0);
        chk({tag, " R1 clear delay"}, int'(delayOut), 0);
      end
      measStart = (i == restartAt) ? 1'b1 : 1'b0;
      rxLine = rxLowAt(i, gS, gL, edgeAt) ? 1'b0 : 1'b1;
      dataPhaseStart = (i == deadline);
    end
    @(negedge clk);
    measStart = 1'b0; rxLine = 1'b1; dataPhaseStart = 1'b0; txLine = 1'b1;
    chk({tag, " delay"}, int'(delayOut), eD);
    chk({tag, " ssp"}, int'(sspPos), eS);
    chk({tag, " valid"}, int'(sspValid), eV);
    lastDelay = eD; lastSsp = eS; lastValid = eV;
  endtask

  task automatic ignoredStart(input string tag, input bit brs, input bit tx);
    @(negedge clk);
    brsActive = brs; txLine = tx; measStart = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      measStart = 1'b0; rxLine = 1'b0;
      dataPhaseStart = (i == 4);
    end
    @(negedge clk);
    rxLine = 1'b1; dataPhaseStart = 1'b0; txLine = 1'b1;
    chk({tag, " R2/R9 delay held"}, int'(delayOut), lastDelay);
    chk({tag, " R2/R9 ssp held"}, int'(sspPos), lastSsp);
    chk({tag, " R2/R9 valid held"}, int'(sspValid), lastValid);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk("R10 reset delay", int'(delayOut), 0);
    chk("R10 reset ssp", int'(sspPos), 0);
    chk("R10 reset valid", int'(sspValid), 0);

    runFrame("R3 R4 R5 basic", 5, 0, 0, 1000, 0, 10, 60, -1);
    runFrame("R5 glitch stops", 5, 0, 0, 3, 2, 20, 60, -1);
    runFrame("R6 glitch ignored", 5, 12, 1, 3, 2, 20, 60, -1);
    runFrame("R6 late window", 2, 10, 1, 1000, 0, 4, 60, -1);
    runFrame("R6 at minimum", 4, 14, 1, 10, 1, 30, 60, -1);
    runFrame("R8 timeout", 5, 0, 0, 1000, 0, 100, 30, -1);
    runFrame("R8 stop priority", 3, 0, 0, 1000, 0, 15, 15, -1);
    runFrame("R7 saturation", 0, 0, 0, 1000, 0, 250, 180, -1);
    runFrame("R4 ssp saturation", 200, 0, 0, 1000, 0, 100, 150, -1);
    ignoredStart("brs off", 1'b0, 1'b0);
    ignoredStart("tx recessive", 1'b1, 1'b1);
    runFrame("R2 restart ignored", 6, 0, 0, 1000, 0, 12, 40, 4);

    for (int n = 0; n < 30; n++) begin
      int off = $urandom_range(0, 255);
      int fmin = $urandom_range(0, 255);
      bit fen = 1'($urandom_range(0, 1));
      int gS = $urandom_range(0, 20);
      int gL = $urandom_range(0, 4);
      int edgeAt = $urandom_range(0, 160);
      int dl = $urandom_range(5, 170);
      runFrame("R3 R6 R8 random", off, fmin, fen, gS, gL, edgeAt, dl, -1);
    end

    // R10: reset during a measurement
    @(negedge clk);
    brsActive = 1'b1; txLine = 1'b0; measStart = 1'b1; offsetVal = 8'd9;
    @(negedge clk);
    measStart = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; rxLine = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rxLine = 1'b1;
    chk("R10 mid reset valid", int'(sspValid), 0);
    chk("R10 mid reset delay", int'(delayOut), 0);
    chk("R10 mid reset ssp", int'(sspPos), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule